// File: doc/BRIEF.md
# Mailbox Interrupt Flags for a Two-Port Shared Memory

This block produces the two interrupt flags that let the two sides of a shared 8K x 9 memory signal each other. Each side owns one mailbox word at the top of the address space. Port 0 owns 0x1FFE and port 1 owns 0x1FFF. When one side writes into the other side's mailbox, the receiving side's interrupt goes active. When the receiving side then accesses its own mailbox with output enable asserted, the interrupt goes inactive again.

The block only observes each port's active-low enable, write strobe and output enable, together with its 13-bit address. The mailbox words themselves stay ordinary memory cells, and the memory array stores the message written there. The block only produces the side-effect flags. A feature-enable input turns the mechanism on. While it is low, both flags stay inactive, and the two top addresses behave as plain storage.

The flags are registered and active-low. They change on the clock edge that samples the qualifying access.

Top module: `mbox_irq_top`

## Requirements
- R1: After reset, both `p0_irq_n` and `p1_irq_n` are high (inactive).
- R2: With `feature_en` high, suppose that at a rising edge `p1_en_n`=0, `p1_wr_n`=0 and `p1_addr`=0x1FFE. Then `p0_irq_n` is low after that edge.
- R3: With `feature_en` high, suppose that at a rising edge `p0_en_n`=0, `p0_wr_n`=0 and `p0_addr`=0x1FFF. Then `p1_irq_n` is low after that edge.
- R4: Suppose that at a rising edge `p0_en_n`=0, `p0_oe_n`=0 and `p0_addr`=0x1FFE, and no R2 set occurs in that cycle. Then `p0_irq_n` is high after that edge, whatever the value of `p0_wr_n`.
- R5: Suppose that at a rising edge `p1_en_n`=0, `p1_oe_n`=0 and `p1_addr`=0x1FFF, and no R3 set occurs in that cycle. Then `p1_irq_n` is high after that edge, whatever the value of `p1_wr_n`.
- R6: When a set and a clear of the same flag fall in the same cycle, the set wins and the flag ends active.
- R7: While `feature_en` is low, both flags are high after every edge, and writes to the mailbox addresses set nothing.
- R8: Accesses that do not qualify change no flag. These include:
  - a write with the enable high;
  - a write to any other address;
  - a port writing its own mailbox;
  - a mailbox access with `oe_n` high.
- R9: In a cycle with no set and no clear, each flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feature_en | input | 1 | Enables the mailbox interrupt mechanism |
| p0_en_n | input | 1 | Port 0 enable, active low |
| p0_wr_n | input | 1 | Port 0 write strobe, active low |
| p0_oe_n | input | 1 | Port 0 output enable, active low |
| p0_addr | input | 13 | Port 0 address |
| p1_en_n | input | 1 | Port 1 enable, active low |
| p1_wr_n | input | 1 | Port 1 write strobe, active low |
| p1_oe_n | input | 1 | Port 1 output enable, active low |
| p1_addr | input | 13 | Port 1 address |
| p0_irq_n | output | 1 | Interrupt to port 0, active low |
| p1_irq_n | output | 1 | Interrupt to port 1, active low |

## Verification
The bench targets mailbox crossover: each port writes its own mailbox and the neighbouring address. A design with swapped or off-by-one mailbox decodes would raise the wrong flag there. It clears with the write strobe held low, which catches a clear that wrongly needs a read. It also drives a set and a clear into the same cycle, where a clear-priority design would lose the message. Finally, it drops the feature enable with flags already pending, which exposes a design that only masks new sets and leaves old ones standing.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned NUM_PORTS = 2;

  // A write cycle: port enabled and write strobe asserted (both active low).
  function automatic logic is_write(input logic en_n, input logic wr_n);
    return (!en_n) && (!wr_n);
  endfunction

  // A read-style access: port enabled and output enable asserted.
  function automatic logic is_oe_access(input logic en_n, input logic oe_n);
    return (!en_n) && (!oe_n);
  endfunction

  // Next flag value: set has priority over clear, disable forces clear.
  function automatic logic next_flag(input logic cur, input logic on,
                                     input logic set, input logic clr);
    if (!on)      return 1'b0;
    else if (set) return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
  parameter int unsigned        ADDR_W   = 13,
  parameter logic [ADDR_W-1:0]  OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0]  PEER_BOX = '0
) (
  input  logic              en_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_peer_box,
  output logic              acc_own_box
);
  import mbox_pkg::*;

  always_comb begin
    wr_peer_box = is_write(en_n, wr_n) && (addr == PEER_BOX);
    acc_own_box = is_oe_access(en_n, oe_n) && (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic on,
  input  logic set,
  input  logic clr,
  output logic flag_n
);
  import mbox_pkg::*;

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= next_flag(flag_q, on, set, clr);
  end

  assign flag_n = ~flag_q;
endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feature_en,
  input  logic              p0_en_n,
  input  logic              p0_wr_n,
  input  logic              p0_oe_n,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic              p1_en_n,
  input  logic              p1_wr_n,
  input  logic              p1_oe_n,
  input  logic [ADDR_W-1:0] p1_addr,
  output logic              p0_irq_n,
  output logic              p1_irq_n
);
  import mbox_pkg::*;

  localparam logic [ADDR_W-1:0] BOX_P1 = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_P0 = BOX_P1 - 1'b1;

  logic [NUM_PORTS-1:0]             en_n_v, wr_n_v, oe_n_v;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
  logic [NUM_PORTS-1:0]             wr_peer, acc_own;
  logic [NUM_PORTS-1:0]             set_evt, clr_evt, irq_n_v;

  assign en_n_v = {p1_en_n, p0_en_n};
  assign wr_n_v = {p1_wr_n, p0_wr_n};
  assign oe_n_v = {p1_oe_n, p0_oe_n};
  assign addr_v = {p1_addr, p0_addr};

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (i == 0) ? BOX_P0 : BOX_P1;
    localparam logic [ADDR_W-1:0] PEER = (i == 0) ? BOX_P1 : BOX_P0;

    mbox_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(OWN), .PEER_BOX(PEER)) i_dec (
      .en_n        (en_n_v[i]),
      .wr_n        (wr_n_v[i]),
      .oe_n        (oe_n_v[i]),
      .addr        (addr_v[i]),
      .wr_peer_box (wr_peer[i]),
      .acc_own_box (acc_own[i])
    );

    // The flag of port i is set by the other port writing into port i's box.
    assign set_evt[i] = feature_en && wr_peer[NUM_PORTS-1-i];
    assign clr_evt[i] = acc_own[i];

    mbox_flag i_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .on     (feature_en),
      .set    (set_evt[i]),
      .clr    (clr_evt[i]),
      .flag_n (irq_n_v[i])
    );
  end

  assign p0_irq_n = irq_n_v[0];
  assign p1_irq_n = irq_n_v[1];
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              feature_en,
  input logic              p0_en_n,
  input logic              p0_wr_n,
  input logic              p0_oe_n,
  input logic [ADDR_W-1:0] p0_addr,
  input logic              p1_en_n,
  input logic              p1_wr_n,
  input logic              p1_oe_n,
  input logic [ADDR_W-1:0] p1_addr,
  input logic              p0_irq_n,
  input logic              p1_irq_n,
  input logic [1:0]        set_evt,
  input logic [1:0]        clr_evt
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic w1_to_box0, w0_to_box1, a0_box0, a1_box1;
  assign w1_to_box0 = !p1_en_n && !p1_wr_n && (p1_addr == TOP - 1'b1);
  assign w0_to_box1 = !p0_en_n && !p0_wr_n && (p0_addr == TOP);
  assign a0_box0    = !p0_en_n && !p0_oe_n && (p0_addr == TOP - 1'b1);
  assign a1_box1    = !p1_en_n && !p1_oe_n && (p1_addr == TOP);

  p_set_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (feature_en && w1_to_box0) |=> !p0_irq_n);
  p_set_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (feature_en && w0_to_box1) |=> !p1_irq_n);
  p_clr_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a0_box0 && !(feature_en && w1_to_box0)) |=> p0_irq_n);
  p_clr_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a1_box1 && !(feature_en && w0_to_box1)) |=> p1_irq_n);
  p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !feature_en |=> (p0_irq_n && p1_irq_n));
  p_hold_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (feature_en && !set_evt[0] && !clr_evt[0]) |=> $stable(p0_irq_n));
  p_hold_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (feature_en && !set_evt[1] && !clr_evt[1]) |=> $stable(p1_irq_n));
endmodule

bind mbox_irq_top mbox_irq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .feature_en(feature_en),
  .p0_en_n(p0_en_n), .p0_wr_n(p0_wr_n), .p0_oe_n(p0_oe_n), .p0_addr(p0_addr),
  .p1_en_n(p1_en_n), .p1_wr_n(p1_wr_n), .p1_oe_n(p1_oe_n), .p1_addr(p1_addr),
  .p0_irq_n(p0_irq_n), .p1_irq_n(p1_irq_n),
  .set_evt(set_evt), .clr_evt(clr_evt)
);

// File: tb/test_mbox_irq_top.sv
module test_mbox_irq_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam logic [AW-1:0] BOX0 = 13'h1FFE;
  localparam logic [AW-1:0] BOX1 = 13'h1FFF;

  logic clk = 0, rst_n = 0, feature_en = 0;
  logic p0_en_n = 1, p0_wr_n = 1, p0_oe_n = 1;
  logic p1_en_n = 1, p1_wr_n = 1, p1_oe_n = 1;
  logic [AW-1:0] p0_addr = '0, p1_addr = '0;
  logic p0_irq_n, p1_irq_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_irq_top #(.ADDR_W(AW)) i_mbox_irq_top (.*);

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    p0_en_n = 1; p0_wr_n = 1; p0_oe_n = 1; p0_addr = '0;
    p1_en_n = 1; p1_wr_n = 1; p1_oe_n = 1; p1_addr = '0;
  endtask

  // Drive one port's access for exactly one edge, then sample.
  task automatic acc(input int port, input logic en_n, input logic wr_n,
                     input logic oe_n, input logic [AW-1:0] a);
    if (port == 0) begin p0_en_n = en_n; p0_wr_n = wr_n; p0_oe_n = oe_n; p0_addr = a; end
    else           begin p1_en_n = en_n; p1_wr_n = wr_n; p1_oe_n = oe_n; p1_addr = a; end
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic t_reset();
    check("R1 p0_irq_n", p0_irq_n, 1'b1);
    check("R1 p1_irq_n", p1_irq_n, 1'b1);
  endtask

  task automatic t_left();
    acc(1, 0, 0, 1, BOX0); step();
    check("R2 p0 set", p0_irq_n, 1'b0);
    check("R2 p1 untouched", p1_irq_n, 1'b1);
    step();
    check("R9 p0 hold", p0_irq_n, 1'b0);
    acc(0, 0, 1, 1, BOX0); step();          // oe_n high: no clear
    check("R8 no clear without oe", p0_irq_n, 1'b0);
    acc(0, 0, 0, 0, BOX0); step();          // wr_n low: still clears
    check("R4 clear wr low", p0_irq_n, 1'b1);
  endtask

  task automatic t_right();
    acc(0, 0, 0, 1, BOX1); step();
    check("R3 p1 set", p1_irq_n, 1'b0);
    check("R3 p0 untouched", p0_irq_n, 1'b1);
    acc(1, 0, 1, 0, BOX1); step();
    check("R5 clear wr high", p1_irq_n, 1'b1);
  endtask

  task automatic t_nonqual();
    acc(0, 0, 0, 1, BOX0); step();          // own box write
    check("R8 own box p0", p0_irq_n, 1'b1);
    acc(1, 0, 0, 1, BOX1); step();
    check("R8 own box p1", p1_irq_n, 1'b1);
    acc(1, 1, 0, 1, BOX0); step();          // enable high
    check("R8 disabled port", p0_irq_n, 1'b1);
    acc(1, 0, 0, 1, 13'h1FFD); step();      // neighbour address
    check("R8 other addr p0", p0_irq_n, 1'b1);
    acc(0, 0, 0, 1, BOX0 - 1'b1); step();
    check("R8 other addr p1", p1_irq_n, 1'b1);
  endtask

  task automatic t_collide();
    acc(1, 0, 0, 1, BOX0); acc(0, 0, 1, 0, BOX0); step();
    check("R6 set beats clear p0", p0_irq_n, 1'b0);
    acc(0, 0, 0, 1, BOX1); acc(1, 0, 1, 0, BOX1); step();
    check("R6 set beats clear p1", p1_irq_n, 1'b0);
    check("R9 p0 kept", p0_irq_n, 1'b0);
  endtask

  task automatic t_disable();
    feature_en = 0; step();
    check("R7 p0 dropped", p0_irq_n, 1'b1);
    check("R7 p1 dropped", p1_irq_n, 1'b1);
    acc(1, 0, 0, 1, BOX0); acc(0, 0, 0, 1, BOX1); step();
    check("R7 no set p0", p0_irq_n, 1'b1);
    check("R7 no set p1", p1_irq_n, 1'b1);
    feature_en = 1; step();
    check("R7 no latent p0", p0_irq_n, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    rst_n = 1; feature_en = 1;
    step();
    t_reset();
    t_left();
    t_right();
    t_nonqual();
    t_collide();
    t_disable();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule